// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer with a small word-addressed register port. A 31-bit counter advances on an external tick enable while the timer is enabled. A 16-bit window of that counter is compared against a compare register. The window starts at a bit position chosen by a 4-bit scale field. When the window reaches the compare value, a sticky pending flag is raised. The block then either sends a one-cycle reset request toward the chip's reset circuitry or, in periodic mode, clears the counter so that it fires again at a fixed interval.

Any register can be read at any time. Every write to a register other than the key register must first be armed by writing a magic key. The arming is used up by the next write of any kind, so each key write permits exactly one modification. Feeding the watchdog needs a second magic value written to a feed address, and that address holds no state. Software stops the timer from expiring by writing the key and then the feed value. With reset requests disabled and auto-zero set, the block runs as a periodic interrupt source.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, config (offset 0x00) reads 0, count (0x08) reads 0, compare (0x20) reads 0xFFFF, the key status (0x1C) reads 0, and both `wdt_rst_o` and `irq_o` are low.
- R2: A write to config, count, compare or feed while the block is not armed changes no register.
- R3: Writing 0x51F15E to offset 0x1C arms the block, and offset 0x1C then reads 1. Exactly one following write takes effect; a second write without re-arming is ignored, and 0x1C reads 0 again.
- R4: Any write disarms the block, including a write of a wrong value to the key offset.
- R5: An armed write of 0xD09F00D to offset 0x18 sets the count to 0. An armed write of any other value there leaves the count unchanged. Offset 0x18 always reads 0.
- R6: The count rises by one on each clock where `tick_i` is high and the enable bit (config bit 6) is set. It holds while the timer is disabled.
- R7: Offset 0x10 reads count bits [scale+15:scale], where scale is config bits [3:0].
- R8: When the scaled count is greater than or equal to the compare value, the pending flag (config bit 7, mirrored on `irq_o`) is set on the next clock. It stays set until an armed config write with bit 7 clear is made while the match is absent.
- R9: With enable and reset-enable (config bit 5) set, `wdt_rst_o` goes high for exactly one cycle, one clock after the match appears. It does not pulse again until the match has gone away, for example through a feed.
- R10: With auto-zero (config bit 4) set, the count returns to 0 one clock after a match. With reset-enable clear, no reset pulse is produced.
- R11: Reads of unmapped offsets return 0, and reads never need the block to be armed.
- R12: An armed write to offset 0x08 loads the count with the written value (bits [30:0]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count-advance enable from the prescaler |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 6 | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| wdt_rst_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | Sticky interrupt pending |

## Verification
The assertions assume that `tick_i` and the write strobe hold stable for a whole cycle. They also assume that a write is presented for exactly one clock, so that arming and consumption pair up one write at a time. The bench drives every input one time unit after a rising edge and holds each write for a single cycle. It lowers `tick_i` before reading a count, so the value cannot move under a check. Comparator tests keep the compare value small and load the counter through the register port instead of waiting on long tick runs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 6;
    localparam int SCALE_W = 4;

    localparam logic [DATA_W-1:0] UNLOCK_CODE = 32'h0051_F15E;
    localparam logic [DATA_W-1:0] FEED_CODE   = 32'h0D09_F00D;

    localparam logic [ADDR_W-1:0] OFS_CFG  = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_SCNT = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_FEED = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_KEY  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_CMP  = 6'h20;

    // bit 7 pending, bit 6 enable, bit 5 reset-enable, bit 4 auto-zero, bits 3:0 scale
    typedef struct packed {
        logic               pend;
        logic               enable;
        logic               rst_en;
        logic               auto_zero;
        logic [SCALE_W-1:0] scale;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_CNT,
        SEL_SCNT,
        SEL_KEY,
        SEL_CMP
    } rd_sel_e;

    function automatic rd_sel_e decode_rd(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CFG:  return SEL_CFG;
            OFS_CNT:  return SEL_CNT;
            OFS_SCNT: return SEL_SCNT;
            OFS_KEY:  return SEL_KEY;
            OFS_CMP:  return SEL_CMP;
            default:  return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
    import wdt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  logic              key_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              armed_o
);

    logic armed_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            armed_q <= 1'b0;
        end else if (wr_i) begin
            armed_q <= key_addr_i && (wdata_i == UNLOCK_CODE);
        end
    end

    assign armed_o = armed_q;

    // R4: any write that is not a correct key write leaves the block disarmed
    p_write_disarms_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && !key_addr_i) |=> !armed_o);

    // R3: a correct key write arms the block
    p_key_arms_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_i && key_addr_i && wdata_i == UNLOCK_CODE) |=> armed_o);

endmodule

// File: rtl/wdt_ctrl_regs.sv
module wdt_ctrl_regs
    import wdt_pkg::*;
#(
    parameter int CMP_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             cmp_we_i,
    input  logic [CMP_W-1:0] cmp_wdata_i,
    input  logic             hit_i,
    output cfg_t             cfg_o,
    output logic [CMP_W-1:0] cmp_o
);

    cfg_t             cfg_q;
    cfg_t             cfg_wr;
    logic [CMP_W-1:0] cmp_q;

    always_comb begin
        cfg_wr = cfg_t'(cfg_wdata_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q <= '0;
        end else begin
            if (cfg_we_i) begin
                cfg_q.enable    <= cfg_wr.enable;
                cfg_q.rst_en    <= cfg_wr.rst_en;
                cfg_q.auto_zero <= cfg_wr.auto_zero;
                cfg_q.scale     <= cfg_wr.scale;
            end
            cfg_q.pend <= (cfg_we_i ? cfg_wr.pend : cfg_q.pend) | hit_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cmp_q <= '1;
        end else if (cmp_we_i) begin
            cmp_q <= cmp_wdata_i;
        end
    end

    assign cfg_o = cfg_q;
    assign cmp_o = cmp_q;

    // R8: pending stays set unless software writes config
    p_pend_sticky_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (cfg_o.pend && !cfg_we_i) |=> cfg_o.pend);

    // R8: a match always leaves pending set on the next clock
    p_hit_sets_pend_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_i |=> cfg_o.pend);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int CNT_W = 31,
    parameter int CMP_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               tick_i,
    input  logic               feed_i,
    input  logic               load_i,
    input  logic [CNT_W-1:0]   load_val_i,
    input  cfg_t               cfg_i,
    input  logic [CMP_W-1:0]   cmp_i,
    output logic [CNT_W-1:0]   cnt_o,
    output logic [CMP_W-1:0]   scaled_o,
    output logic               hit_o,
    output logic               rst_pulse_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] shifted;
    logic             hit;
    logic             fire_cond;
    logic             fired_q;
    logic             pulse_q;

    always_comb begin
        shifted  = cnt_q >> cfg_i.scale;
        scaled_o = shifted[CMP_W-1:0];
        hit      = (scaled_o >= cmp_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (feed_i) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (hit && cfg_i.auto_zero) begin
            cnt_q <= '0;
        end else if (tick_i && cfg_i.enable) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fire_cond = hit && cfg_i.enable && cfg_i.rst_en;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fired_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire_cond && !fired_q;
            fired_q <= hit && (fired_q || fire_cond);
        end
    end

    assign cnt_o       = cnt_q;
    assign hit_o       = hit;
    assign rst_pulse_o = pulse_q;

    // R9: the reset request never lasts longer than one cycle
    p_rst_one_cycle_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_pulse_o |=> !rst_pulse_o);

    // R9: a reset request needs enable and reset-enable one clock earlier
    p_rst_needs_enable_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        rst_pulse_o |-> $past(cfg_i.enable && cfg_i.rst_en && hit_o));

    // R6: with the timer disabled and no bus or match action, the count holds
    p_count_holds_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cfg_i.enable && !feed_i && !load_i && !hit_o) |=> $stable(cnt_o));

    // R10: auto-zero clears the count after a match
    p_auto_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        (hit_o && cfg_i.auto_zero && !load_i) |=> (cnt_o == '0));

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_pkg::*;
#(
    parameter int CNT_W = 31,
    parameter int CMP_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              wdt_rst_o,
    output logic              irq_o
);

    logic             armed;
    logic             key_addr;
    logic             wr_ok;
    logic             cfg_we;
    logic             cmp_we;
    logic             cnt_we;
    logic             feed_ok;
    cfg_t             cfg;
    logic [CMP_W-1:0] cmp;
    logic [CNT_W-1:0] cnt;
    logic [CMP_W-1:0] scaled;
    logic             hit;
    rd_sel_e          rd_sel;

    assign key_addr = (addr_i == OFS_KEY);
    assign wr_ok    = wr_en_i && armed && !key_addr;
    assign cfg_we   = wr_ok && (addr_i == OFS_CFG);
    assign cmp_we   = wr_ok && (addr_i == OFS_CMP);
    assign cnt_we   = wr_ok && (addr_i == OFS_CNT);
    assign feed_ok  = wr_ok && (addr_i == OFS_FEED) && (wdata_i == FEED_CODE);

    wdt_unlock u_unlock (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .wr_i       (wr_en_i),
        .key_addr_i (key_addr),
        .wdata_i    (wdata_i),
        .armed_o    (armed)
    );

    wdt_ctrl_regs #(.CMP_W(CMP_W)) u_regs (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .cfg_we_i    (cfg_we),
        .cfg_wdata_i (wdata_i[CFG_W-1:0]),
        .cmp_we_i    (cmp_we),
        .cmp_wdata_i (wdata_i[CMP_W-1:0]),
        .hit_i       (hit),
        .cfg_o       (cfg),
        .cmp_o       (cmp)
    );

    wdt_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_counter (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .tick_i      (tick_i),
        .feed_i      (feed_ok),
        .load_i      (cnt_we),
        .load_val_i  (wdata_i[CNT_W-1:0]),
        .cfg_i       (cfg),
        .cmp_i       (cmp),
        .cnt_o       (cnt),
        .scaled_o    (scaled),
        .hit_o       (hit),
        .rst_pulse_o (wdt_rst_o)
    );

    always_comb begin
        rd_sel = decode_rd(addr_i);
        case (rd_sel)
            SEL_CFG:  rdata_o = DATA_W'(cfg);
            SEL_CNT:  rdata_o = DATA_W'(cnt);
            SEL_SCNT: rdata_o = DATA_W'(scaled);
            SEL_KEY:  rdata_o = DATA_W'(armed);
            SEL_CMP:  rdata_o = DATA_W'(cmp);
            default:  rdata_o = '0;
        endcase
    end

    assign irq_o = cfg.pend;

    // R2: a config write while disarmed leaves the software fields untouched
    p_locked_cfg_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !armed && addr_i == OFS_CFG) |=> $stable(cfg[CFG_W-2:0]));

    // R2: a compare write while disarmed leaves the compare value untouched
    p_locked_cmp_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && !armed && addr_i == OFS_CMP) |=> $stable(cmp));

    // R5: an accepted feed clears the count
    p_feed_clears_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && armed && addr_i == OFS_FEED && wdata_i == FEED_CODE) |=> (cnt == '0));

    // R11: unmapped offsets read as zero
    p_unmapped_zero_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_sel == SEL_NONE) |-> (rdata_o == '0));

endmodule

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
    import wdt_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst;
    logic              tick;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              wdt_rst;
    logic              irq;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done     = 1'b0;

    logic        chk_req = 1'b0;
    int          chk_sel = 0;   // 0 rdata, 1 wdt_rst, 2 irq
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_keyed dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .wdt_rst_o (wdt_rst),
        .irq_o     (irq)
    );

    // monitor: pops the expected item and compares with the observed value
    always @(negedge clk) begin
        if (chk_req) begin
            logic [31:0] act;
            logic [31:0] exp;
            string       tag;
            act = (chk_sel == 0) ? rdata : (chk_sel == 1) ? {31'b0, wdt_rst} : {31'b0, irq};
            exp = exp_q.pop_front();
            tag = tag_q.pop_front();
            n_checks++;
            if (act !== exp) begin
                n_errors++;
                $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic armed_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        wr_reg(OFS_KEY, UNLOCK_CODE);
        wr_reg(a, d);
    endtask

    task automatic expect_val(input int sel, input logic [ADDR_W-1:0] a,
                              input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        addr = a; chk_sel = sel; chk_req = 1'b1;
        step();
        chk_req = 1'b0;
    endtask

    task automatic expect_rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        expect_val(0, a, e, tag);
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        expect_rd(OFS_CFG, 32'h0, "R1 cfg");
        expect_rd(OFS_CNT, 32'h0, "R1 count");
        expect_rd(OFS_CMP, 32'hFFFF, "R1 compare");
        expect_rd(OFS_KEY, 32'h0, "R1 key status");
        expect_val(1, OFS_CFG, 32'h0, "R1 rst out");
        expect_val(2, OFS_CFG, 32'h0, "R1 irq out");

        // R6 disabled timer does not count
        ticks(4);
        expect_rd(OFS_CNT, 32'h0, "R6 disabled hold");

        // R2 write without arming is ignored
        wr_reg(OFS_CFG, 32'h40);
        expect_rd(OFS_CFG, 32'h0, "R2 locked cfg");

        // R3 arm, one write, then locked again
        wr_reg(OFS_KEY, UNLOCK_CODE);
        expect_rd(OFS_KEY, 32'h1, "R3 armed status");
        wr_reg(OFS_CMP, 32'h5);
        expect_rd(OFS_CMP, 32'h5, "R3 armed write");
        expect_rd(OFS_KEY, 32'h0, "R3 consumed");
        wr_reg(OFS_CMP, 32'h9);
        expect_rd(OFS_CMP, 32'h5, "R3 second write ignored");

        // R4 wrong key disarms
        wr_reg(OFS_KEY, UNLOCK_CODE);
        wr_reg(OFS_KEY, 32'h1);
        wr_reg(OFS_CMP, 32'h7);
        expect_rd(OFS_CMP, 32'h5, "R4 wrong key disarms");

        // R6 enabled timer counts ticks
        armed_wr(OFS_CFG, 32'h40);
        expect_rd(OFS_CFG, 32'h40, "R6 cfg enable");
        ticks(3);
        expect_rd(OFS_CNT, 32'h3, "R6 counts ticks");

        // R5 feed
        armed_wr(OFS_FEED, 32'h1234);
        expect_rd(OFS_CNT, 32'h3, "R5 wrong feed value");
        expect_rd(OFS_FEED, 32'h0, "R5 feed reads zero");
        armed_wr(OFS_FEED, FEED_CODE);
        expect_rd(OFS_CNT, 32'h0, "R5 feed clears");

        // R9 reset pulse
        armed_wr(OFS_CFG, 32'h60);
        ticks(5);
        expect_val(1, OFS_CNT, 32'h0, "R9 no pulse on match cycle");
        expect_val(1, OFS_CNT, 32'h1, "R9 pulse");
        expect_val(1, OFS_CNT, 32'h0, "R9 pulse one cycle");
        expect_val(1, OFS_CNT, 32'h0, "R9 no repeat");
        expect_val(2, OFS_CNT, 32'h1, "R8 pending set");
        armed_wr(OFS_FEED, FEED_CODE);
        expect_val(2, OFS_CNT, 32'h1, "R8 pending sticky after feed");
        ticks(5);
        expect_val(1, OFS_CNT, 32'h0, "R9 rearm match cycle");
        expect_val(1, OFS_CNT, 32'h1, "R9 rearmed pulse");

        // R8 clear pending
        armed_wr(OFS_FEED, FEED_CODE);
        armed_wr(OFS_CFG, 32'h40);
        expect_val(2, OFS_CFG, 32'h0, "R8 pending cleared");
        expect_rd(OFS_CFG, 32'h40, "R8 cfg after clear");

        // R10 auto-zero periodic mode
        armed_wr(OFS_CMP, 32'h3);
        armed_wr(OFS_CFG, 32'h50);
        ticks(3);
        expect_rd(OFS_CNT, 32'h3, "R10 count at match");
        expect_val(1, OFS_CNT, 32'h0, "R10 no reset pulse");
        expect_rd(OFS_CNT, 32'h0, "R10 auto zero");
        expect_val(2, OFS_CNT, 32'h1, "R10 irq raised");

        // R12 / R7 count load and scaling
        armed_wr(OFS_CMP, 32'hFFFF);
        armed_wr(OFS_CFG, 32'h02);
        armed_wr(OFS_CNT, 32'h2C);
        expect_rd(OFS_CNT, 32'h2C, "R12 count load");
        expect_rd(OFS_SCNT, 32'h0B, "R7 scale 2");
        expect_rd(OFS_CFG, 32'h02, "R8 cfg write clears pending");
        armed_wr(OFS_CFG, 32'h0F);
        armed_wr(OFS_CNT, 32'h7FFF_8000);
        expect_rd(OFS_SCNT, 32'hFFFF, "R7 scale 15");

        // R11 unmapped reads
        expect_rd(6'h04, 32'h0, "R11 unmapped 0x04");
        expect_rd(6'h3C, 32'h0, "R11 unmapped 0x3C");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule